// File: doc/BRIEF.md
# Scalar Memory Clause Conflict Detector

This block decides whether a newly proposed scalar memory instruction may join the group of back-to-back scalar memory instructions issued just before it. Members of such a group may complete out of order or be issued again, so the group is only safe when no register that any member writes is also read by any member. That includes a single instruction reading its own destination.

The issue logic reports every issued slot to the block. A slot is a scalar memory operation, some other instruction, or an empty slot. Each report carries the slot's destination and source register masks over 64 scalar registers. The block keeps the last five slots. It forms the current run by walking from the newest slot backwards until it meets the first slot that is not a scalar memory operation.

When a candidate is presented, the block adds the candidate's own masks to the run's masks and tests the combined write and read sets for overlap. Stores get special treatment, as described in the requirements. One cycle later it reports whether a single filler instruction must be placed before the candidate. A mode input selects the later instruction-set generation; in the earlier generation the check is off.

Top module: `smcg_top`

## Requirements
- R1: After reset `brk_valid` and `brk_req` are 0 and the kept history holds only empty slots. A candidate checked right after reset therefore gets `brk_req` = 0, even if it reads its own destination.
- R2: `brk_valid` is 1 in exactly the cycle after a cycle with `cand_valid` = 1 and 0 otherwise. `brk_req` is 0 whenever `brk_valid` is 0.
- R3: With `gen_late` = 0 the result is always 0.
- R4: When the union of destination masks over the current run (candidate excluded) is zero, the result is 0. This holds even for a store or a self-conflicting candidate.
- R5: A store candidate (`cand_store` = 1) gets result 1 whenever the run holds at least one destination register and `gen_late` = 1.
- R6: The run's write union together with the candidate's write mask is ANDed with the run's read union together with the candidate's read mask. A non-zero AND gives result 1. Overlap may lie within the run, between run and candidate, or within the candidate alone.
- R7: The run is the newest history slots up to, not including, the first slot whose kind is not scalar memory. Kind encoding on `iss_kind`: 2'b10 scalar memory, 2'b01 other instruction, 2'b00 empty slot, 2'b11 treated as other. Older scalar memory slots beyond that point have no effect.
- R8: Only the five most recent pushed slots are kept. A slot pushed six or more pushes ago has no effect.
- R9: With `gen_late` = 1 and a non-store candidate, disjoint write and read unions give result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_late | input | 1 | 1 enables the check (later generation) |
| iss_valid | input | 1 | Push one issued slot into the history |
| iss_kind | input | 2 | Kind of the pushed slot (see R7) |
| iss_wr_mask | input | 64 | Destination registers of the pushed slot |
| iss_rd_mask | input | 64 | Source registers of the pushed slot |
| cand_valid | input | 1 | Candidate present for checking |
| cand_store | input | 1 | Candidate is a store |
| cand_wr_mask | input | 64 | Candidate destination registers |
| cand_rd_mask | input | 64 | Candidate source registers |
| brk_valid | output | 1 | Result strobe, one cycle after `cand_valid` |
| brk_req | output | 1 | One filler slot is required before the candidate |

## Verification
The bench checks that the run stops at an intervening other-kind slot and at an empty slot. A design that kept scanning past either would flag conflicts against stale loads. It checks the fifth-versus-sixth push boundary using register 63, which catches a history that is one slot too deep or too shallow and a mask that drops high bits. Several cases target the write-union guard: a store or a self-reading candidate behind a run with no destinations must pass. A design that tested the candidate first would wrongly request a break there. Self-conflict, cross-member overlap and the disabled earlier mode are each covered separately, so that a pairwise-only check or an ignored mode input shows up as a miscompare.

// File: rtl/smcg_pkg.sv
package smcg_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'b00,
    SLOT_OTHER = 2'b01,
    SLOT_SMEM  = 2'b10
  } slot_kind_e;

  function automatic logic kind_is_smem(input logic [1:0] k);
    return k == SLOT_SMEM;
  endfunction
endpackage

// File: rtl/smcg_history.sv
module smcg_history
  import smcg_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int NREG  = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [1:0]                  push_kind,
  input  logic [NREG-1:0]             push_wr,
  input  logic [NREG-1:0]             push_rd,
  output logic [DEPTH-1:0][1:0]       h_kind,
  output logic [DEPTH-1:0][NREG-1:0]  h_wr,
  output logic [DEPTH-1:0][NREG-1:0]  h_rd
);
  // Slot 0 is the newest entry; a push shifts every slot one place older.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [1:0]      nxt_kind;
    logic [NREG-1:0] nxt_wr;
    logic [NREG-1:0] nxt_rd;
    if (i == 0) begin : g_head
      assign nxt_kind = push_kind;
      assign nxt_wr   = push_wr;
      assign nxt_rd   = push_rd;
    end else begin : g_body
      assign nxt_kind = h_kind[i-1];
      assign nxt_wr   = h_wr[i-1];
      assign nxt_rd   = h_rd[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h_kind[i] <= SLOT_EMPTY;
        h_wr[i]   <= '0;
        h_rd[i]   <= '0;
      end else if (push) begin
        h_kind[i] <= nxt_kind;
        h_wr[i]   <= nxt_wr;
        h_rd[i]   <= nxt_rd;
      end
    end
  end

  // R8: a push moves the newest entry into slot 1
  a_r8_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> h_wr[1] == $past(h_wr[0]));
endmodule

// File: rtl/smcg_run_scan.sv
module smcg_run_scan
  import smcg_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int NREG  = 64
) (
  input  logic [DEPTH-1:0][1:0]       h_kind,
  input  logic [DEPTH-1:0][NREG-1:0]  h_wr,
  input  logic [DEPTH-1:0][NREG-1:0]  h_rd,
  output logic [NREG-1:0]             run_wr,
  output logic [NREG-1:0]             run_rd,
  output logic                        run_open
);
  // alive[i]: slots 0..i are all scalar memory, so slot i belongs to the run.
  logic [DEPTH-1:0]            alive;
  logic [DEPTH-1:0][NREG-1:0]  acc_wr;
  logic [DEPTH-1:0][NREG-1:0]  acc_rd;

  for (genvar i = 0; i < DEPTH; i++) begin : g_scan
    if (i == 0) begin : g_first
      assign alive[i]  = kind_is_smem(h_kind[i]);
      assign acc_wr[i] = alive[i] ? h_wr[i] : '0;
      assign acc_rd[i] = alive[i] ? h_rd[i] : '0;
    end else begin : g_next
      assign alive[i]  = alive[i-1] & kind_is_smem(h_kind[i]);
      assign acc_wr[i] = acc_wr[i-1] | (alive[i] ? h_wr[i] : '0);
      assign acc_rd[i] = acc_rd[i-1] | (alive[i] ? h_rd[i] : '0);
    end
  end

  assign run_wr   = acc_wr[DEPTH-1];
  assign run_rd   = acc_rd[DEPTH-1];
  assign run_open = alive[0];
endmodule

// File: rtl/smcg_judge.sv
module smcg_judge #(
  parameter int NREG = 64
) (
  input  logic             gen_late,
  input  logic             cand_store,
  input  logic [NREG-1:0]  run_wr,
  input  logic [NREG-1:0]  run_rd,
  input  logic [NREG-1:0]  cand_wr,
  input  logic [NREG-1:0]  cand_rd,
  output logic             need_break
);
  // Decision order matters: mode gate, then empty write union, then store,
  // then the write/read intersection with the candidate folded in.
  function automatic logic decide(
    input logic            late,
    input logic            store,
    input logic [NREG-1:0] rw,
    input logic [NREG-1:0] rr,
    input logic [NREG-1:0] cw,
    input logic [NREG-1:0] cr
  );
    if (!late)      return 1'b0;
    if (rw == '0)   return 1'b0;
    if (store)      return 1'b1;
    return |((rw | cw) & (rr | cr));
  endfunction

  assign need_break = decide(gen_late, cand_store, run_wr, run_rd, cand_wr, cand_rd);
endmodule

// File: rtl/smcg_top.sv
module smcg_top
  import smcg_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int NREG  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_late,
  input  logic             iss_valid,
  input  logic [1:0]       iss_kind,
  input  logic [NREG-1:0]  iss_wr_mask,
  input  logic [NREG-1:0]  iss_rd_mask,
  input  logic             cand_valid,
  input  logic             cand_store,
  input  logic [NREG-1:0]  cand_wr_mask,
  input  logic [NREG-1:0]  cand_rd_mask,
  output logic             brk_valid,
  output logic             brk_req
);
  logic [DEPTH-1:0][1:0]       h_kind;
  logic [DEPTH-1:0][NREG-1:0]  h_wr;
  logic [DEPTH-1:0][NREG-1:0]  h_rd;
  logic [NREG-1:0]             run_wr;
  logic [NREG-1:0]             run_rd;
  logic                        run_open;
  logic                        need_break;

  smcg_history #(.DEPTH(DEPTH), .NREG(NREG)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (iss_valid),
    .push_kind (iss_kind),
    .push_wr   (iss_wr_mask),
    .push_rd   (iss_rd_mask),
    .h_kind    (h_kind),
    .h_wr      (h_wr),
    .h_rd      (h_rd)
  );

  smcg_run_scan #(.DEPTH(DEPTH), .NREG(NREG)) u_scan (
    .h_kind   (h_kind),
    .h_wr     (h_wr),
    .h_rd     (h_rd),
    .run_wr   (run_wr),
    .run_rd   (run_rd),
    .run_open (run_open)
  );

  smcg_judge #(.NREG(NREG)) u_judge (
    .gen_late   (gen_late),
    .cand_store (cand_store),
    .run_wr     (run_wr),
    .run_rd     (run_rd),
    .cand_wr    (cand_wr_mask),
    .cand_rd    (cand_rd_mask),
    .need_break (need_break)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_valid <= 1'b0;
      brk_req   <= 1'b0;
    end else begin
      brk_valid <= cand_valid;
      brk_req   <= cand_valid & need_break;
    end
  end

  // R2: strobe follows the candidate by one cycle
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |=> brk_valid);
  a_r2_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |=> !brk_valid);
  a_r2_req_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> brk_valid);
  // R3: earlier generation never asks for a break
  a_r3_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !gen_late) |=> !brk_req);
  // R4: no run destinations means no break
  a_r4_no_defs: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && run_wr == '0) |=> !brk_req);
  // R5: store behind a run with destinations always breaks
  a_r5_store_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && gen_late && cand_store && run_wr != '0) |=> brk_req);
  // R7: newest slot not scalar memory leaves an empty run
  a_r7_run_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !run_open |-> (run_wr == '0 && run_rd == '0));
endmodule

// File: tb/smcg_top_test.sv
module smcg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_late = 1'b1;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_kind = 2'b00;
  logic [63:0] iss_wr_mask = '0;
  logic [63:0] iss_rd_mask = '0;
  logic        cand_valid = 1'b0;
  logic        cand_store = 1'b0;
  logic [63:0] cand_wr_mask = '0;
  logic [63:0] cand_rd_mask = '0;
  logic        brk_valid;
  logic        brk_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  smcg_top uut (
    .clk(clk), .rst_n(rst_n), .gen_late(gen_late),
    .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_wr_mask(iss_wr_mask), .iss_rd_mask(iss_rd_mask),
    .cand_valid(cand_valid), .cand_store(cand_store),
    .cand_wr_mask(cand_wr_mask), .cand_rd_mask(cand_rd_mask),
    .brk_valid(brk_valid), .brk_req(brk_req)
  );

  always #5 clk = ~clk;

  // Kinds per slot (slot4 oldest .. slot0 newest): 2'b10 smem, 2'b01 other, 2'b00 empty.
  typedef struct packed {
    logic        mode;
    logic        st;
    logic        ex;
    logic [9:0]  k;
    logic [79:0] d;
    logic [79:0] u;
    logic [15:0] cd;
    logic [15:0] cu;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R9 disjoint sets
    '{1'b1, 1'b0, 1'b0, 10'b1010101010, 80'h0001, 80'h0002, 16'h0004, 16'h0008},
    // R6 candidate reads a run destination
    '{1'b1, 1'b0, 1'b1, 10'b1010101010, 80'h0001, 80'h0000, 16'h0000, 16'h0001},
    // R6 candidate writes what an earlier member reads
    '{1'b1, 1'b0, 1'b1, 10'b1010101010, 80'h0000_0000_0000_0000_0001, 80'h0000_0000_0000_0010_0000, 16'h0010, 16'h0000},
    // R7 newest slot is another instruction
    '{1'b1, 1'b0, 1'b0, 10'b1010101001, 80'h0000_0000_0000_0002_0001, 80'h0, 16'h0000, 16'h0002},
    // R7 empty slot ends the run
    '{1'b1, 1'b0, 1'b0, 10'b1010100010, 80'h0000_0000_0008_0000_0000, 80'h0004, 16'h0000, 16'h0008},
    // R4 store behind a run with no destinations
    '{1'b1, 1'b1, 1'b0, 10'b1010101010, 80'h0000, 80'h0001, 16'h0000, 16'h0000},
    // R5 store behind a run with a destination
    '{1'b1, 1'b1, 1'b1, 10'b1010101010, 80'h0002, 80'h0000, 16'h0000, 16'h0000},
    // R3 overlap in earlier mode
    '{1'b0, 1'b0, 1'b0, 10'b1010101010, 80'h0001, 80'h0000, 16'h0000, 16'h0001},
    // R6 candidate reads its own destination
    '{1'b1, 1'b0, 1'b1, 10'b1010101010, 80'h0001, 80'h0000, 16'h0002, 16'h0002},
    // R4 candidate writes a run source but run has no destinations
    '{1'b1, 1'b0, 1'b0, 10'b1010101010, 80'h0000, 80'h0002, 16'h0002, 16'h0000},
    // R6 overlap inside the run
    '{1'b1, 1'b0, 1'b1, 10'b1010101010, 80'h0000_0000_0000_0001_0000, 80'h0001, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [63:0] w, input logic [63:0] r);
    @(negedge clk);
    iss_valid = 1'b1; iss_kind = k; iss_wr_mask = w; iss_rd_mask = r;
  endtask

  task automatic candidate(input logic st, input logic [63:0] w, input logic [63:0] r,
                           input string req, input logic exp);
    @(negedge clk);
    iss_valid = 1'b0;
    cand_valid = 1'b1; cand_store = st; cand_wr_mask = w; cand_rd_mask = r;
    @(negedge clk);
    cand_valid = 1'b0;
    check(req, brk_valid, 1'b1);
    check(req, brk_req, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", brk_valid, 1'b0);
    check("R1 req", brk_req, 1'b0);
    rst_n = 1'b1;
    // R1 empty history: self-conflicting candidate still passes
    candidate(1'b0, 64'h1, 64'h1, "R1 empty history", 1'b0);
    // R2 no strobe without a candidate
    @(negedge clk);
    check("R2 idle strobe", brk_valid, 1'b0);
    check("R2 idle req", brk_req, 1'b0);

    for (int v = 0; v < NV; v++) begin
      gen_late = VECS[v].mode;
      for (int s = 4; s >= 0; s--)
        push(VECS[v].k[s*2 +: 2], {48'b0, VECS[v].d[s*16 +: 16]}, {48'b0, VECS[v].u[s*16 +: 16]});
      candidate(VECS[v].st, {48'b0, VECS[v].cd}, {48'b0, VECS[v].cu},
                $sformatf("vector %0d", v), VECS[v].ex);
    end
    gen_late = 1'b1;

    // R8 a destination on register 63 kept within five pushes
    push(2'b10, 64'h8000_0000_0000_0000, 64'h0);
    for (int i = 0; i < 4; i++) push(2'b10, 64'h0, 64'h0);
    candidate(1'b0, 64'h0, 64'h8000_0000_0000_0000, "R8 fifth slot kept", 1'b1);
    // R8 one more push drops it
    push(2'b10, 64'h0, 64'h0);
    candidate(1'b0, 64'h0, 64'h8000_0000_0000_0000, "R8 sixth slot dropped", 1'b0);

    // R1 reset mid-run clears history
    push(2'b10, 64'h4, 64'h0);
    @(negedge clk);
    iss_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears strobe", brk_valid, 1'b0);
    rst_n = 1'b1;
    candidate(1'b0, 64'h0, 64'h4, "R1 history cleared", 1'b0);

    // R2 back-to-back candidates give back-to-back strobes
    push(2'b10, 64'h10, 64'h0);
    @(negedge clk);
    iss_valid = 1'b0;
    cand_valid = 1'b1; cand_store = 1'b0; cand_wr_mask = '0; cand_rd_mask = 64'h10;
    @(negedge clk);
    check("R2 first strobe", brk_valid, 1'b1);
    check("R6 first result", brk_req, 1'b1);
    cand_rd_mask = 64'h20;
    @(negedge clk);
    cand_valid = 1'b0;
    check("R2 second strobe", brk_valid, 1'b1);
    check("R9 second result", brk_req, 1'b0);
    @(negedge clk);
    check("R2 strobe drops", brk_valid, 1'b0);

    finish_run();
  end
endmodule